// File: doc/BRIEF.md
# Dual-Group Parallel Digital I/O Controller

This block is a 48-line digital I/O peripheral seen by a host through a small 8-bit bus with separate read and write strobes and a 4-bit byte address. The lines form two identical groups. Each group has three 8-bit ports, called A, B and C, and one control register. Ports A and B switch direction as whole bytes. Port C switches direction as two independent nibbles. Each pin is modelled as three signals: a sampled input, a driven output value and an output enable.

A control write with bit 7 set is a mode word. It chooses the direction of each port part and clears every output latch of that group. A control write with bit 7 clear sets or clears a single port C latch bit. Bit 3 of port C in each group can raise an interrupt on a rising edge. The pin is first passed through a synchroniser. A read of offset 0xB disables interrupts, a write of any value to the same offset enables them, and a write to offset 0xF clears a pending request. A single output reports the request.

Top module: `dual_pio_ctrl`

## Requirements
- R1: Port A, B and C are at offsets 0, 1 and 2 for group 0 and at 4, 5 and 6 for group 1. A read strobe at a port offset loads `busRdData` at that clock edge with the current `pinIn` byte of that port, where group g port p occupies pins (g*24 + p*8) to (g*24 + p*8 + 7). A read of any other offset loads 0, and `busRdData` holds its value when no read happens.
- R2: A write to a port offset loads that port's output latch, and the latch drives the port's `pinOut` byte from the next clock.
- R3: A write to a control register (offset 3 for group 0, offset 7 for group 1) with bit 7 set is a mode word. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 0 = 1 makes port C bits 3:0 an input, and bit 3 = 1 makes port C bits 7:4 an input. A 0 in any of these bits makes that part an output. `pinOe` is 1 for output lines and 0 for input lines, and bits 6, 5 and 2 have no effect.
- R4: A mode word clears all three output latches of its group to zero and leaves the other group unchanged.
- R5: A control write with bit 7 clear is a bit command. Bits 3:1 select the port C bit of that group, and bit 0 is the value written to it. No other latch bit and no direction changes.
- R6: A write to a port or nibble that is configured as input still updates its latch, which shows on `pinOut`, while its `pinOe` stays 0.
- R7: After reset every line is an output (the effect of mode 0x80 on both groups), every latch is zero, `busRdData` is 0, interrupts are disabled and `irqOut` is low.
- R8: While interrupts are enabled, a 0-to-1 change on pin 19 or pin 43 raises `irqOut` at the third rising clock edge after the change. Falling edges, edges on other pins and edges while interrupts are disabled do not raise it.
- R9: A read at offset 0xB disables interrupts and drops `irqOut` at that clock edge. A write of any value at offset 0xB enables them.
- R10: A write at offset 0xF drops `irqOut` at that clock edge, unless a qualifying edge is detected in the same cycle.
- R11: Once raised, `irqOut` stays high until a clear write or a disabling read.
- R12: Writes to offsets 8, 9, 0xA, 0xC, 0xD and 0xE change no latch, no direction and no interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset within the 16-byte window |
| busWrData | input | 8 | Write data |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRdData | output | 8 | Registered read data |
| pinIn | input | 48 | Sampled pin levels |
| pinOut | output | 48 | Output latch values |
| pinOe | output | 48 | Output enables, 1 = driven |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle, because the decoder gives neither one priority. The properties about directions, bit commands and interrupt clearing are written against single accesses. The random stimulus issues exactly one access per two-cycle slot, so the strobes are never high together. It also holds pins 19 and 43 low during random traffic, so that no interrupt edge interferes with the read and latch checks. Interrupt behaviour is covered only by the directed sequences.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int GROUPS   = 2;
  localparam int PORTS    = 3;
  localparam int PORT_W   = 8;
  localparam int NIB_W    = PORT_W / 2;
  localparam int GROUP_W  = PORTS * PORT_W;
  localparam int PINS     = GROUPS * GROUP_W;
  localparam int ADDR_W   = 4;
  localparam int IDX_W    = $clog2(GROUPS * PORTS);
  localparam int SEL_W    = $clog2(PORT_W);

  // direction state of one group, 1 = input
  typedef struct packed {
    logic cHi;
    logic cLo;
    logic b;
    logic a;
  } dirSet_t;

  // strobes from decode to datapath
  typedef struct packed {
    logic [GROUPS-1:0]       modeWr;
    logic [GROUPS-1:0]       bitCmd;
    logic [GROUPS*PORTS-1:0] latchWr;
    logic                    rdAny;
    logic                    rdPort;
    logic [IDX_W-1:0]        rdIdx;
    logic [PORT_W-1:0]       data;
  } pioStrobes_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [GROUPS-1:0] irqEdge,
  output pioStrobes_t       stb,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] IRQ_EN_ADDR  = ADDR_W'(4'hB);
  localparam logic [ADDR_W-1:0] IRQ_CLR_ADDR = ADDR_W'(4'hF);

  logic       lowHalf;
  logic [1:0] subSel;
  logic       grpSel;
  logic       isCtrl;
  logic       irqEnable;
  logic       irqPending;
  logic       enWrite;
  logic       disRead;
  logic       clrWrite;

  assign lowHalf = ~busAddr[3];
  assign grpSel  = busAddr[2];
  assign subSel  = busAddr[1:0];
  assign isCtrl  = lowHalf && (subSel == 2'd3);

  always_comb begin
    stb = '0;
    stb.data   = busWrData;
    stb.rdAny  = busRd;
    stb.rdPort = busRd && lowHalf && !isCtrl;
    stb.rdIdx  = IDX_W'(grpSel) * IDX_W'(PORTS) + IDX_W'(subSel);
    for (int g = 0; g < GROUPS; g++) begin
      if (busWr && isCtrl && (int'(grpSel) == g)) begin
        stb.modeWr[g] = busWrData[7];
        stb.bitCmd[g] = ~busWrData[7];
      end
      for (int p = 0; p < PORTS; p++) begin
        stb.latchWr[g*PORTS+p] = busWr && lowHalf && (int'(grpSel) == g)
                                 && (int'(subSel) == p);
      end
    end
  end

  assign enWrite  = busWr && (busAddr == IRQ_EN_ADDR);
  assign disRead  = busRd && (busAddr == IRQ_EN_ADDR);
  assign clrWrite = busWr && (busAddr == IRQ_CLR_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqEnable  <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      if (disRead)      irqEnable <= 1'b0;
      else if (enWrite) irqEnable <= 1'b1;

      if (disRead)                      irqPending <= 1'b0;
      else if (irqEnable && |irqEdge)   irqPending <= 1'b1;
      else if (clrWrite)                irqPending <= 1'b0;
    end
  end

  assign irqOut = irqPending;
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_BIT     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pioStrobes_t       stb,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PORT_W-1:0] rdData,
  output logic [GROUPS-1:0] irqEdge
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [GROUPS-1:0] irqPins;
  logic [GROUPS-1:0] syncQ [SYNC_STAGES];
  logic [GROUPS-1:0] prevQ;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int BASE = g * GROUP_W;
    dirSet_t           dirQ;
    logic [PORT_W-1:0] latA, latB, latC;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirQ <= '0;
        latA <= '0;
        latB <= '0;
        latC <= '0;
      end else if (stb.modeWr[g]) begin
        dirQ <= '{cHi: stb.data[3], cLo: stb.data[0], b: stb.data[1], a: stb.data[4]};
        latA <= '0;
        latB <= '0;
        latC <= '0;
      end else begin
        if (stb.latchWr[g*PORTS+0]) latA <= stb.data;
        if (stb.latchWr[g*PORTS+1]) latB <= stb.data;
        if (stb.latchWr[g*PORTS+2]) latC <= stb.data;
        else if (stb.bitCmd[g])     latC[stb.data[SEL_W:1]] <= stb.data[0];
      end
    end

    assign pinOut[BASE +: GROUP_W] = {latC, latB, latA};
    assign pinOe[BASE +: GROUP_W]  = {{NIB_W{~dirQ.cHi}}, {NIB_W{~dirQ.cLo}},
                                      {PORT_W{~dirQ.b}}, {PORT_W{~dirQ.a}}};
    assign irqPins[g] = pinIn[BASE + 2*PORT_W + IRQ_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= irqPins;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign irqEdge = syncQ[LAST] & ~prevQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (stb.rdAny) begin
      rdData <= stb.rdPort ? pinIn[stb.rdIdx*PORT_W +: PORT_W] : '0;
    end
  end
endmodule

// File: rtl/dual_pio_ctrl.sv
module dual_pio_ctrl
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_BIT     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [PORT_W-1:0] busRdData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);
  pioStrobes_t       stb;
  logic [GROUPS-1:0] irqEdge;

  pio_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRd     (busRd),
    .busWr     (busWr),
    .irqEdge   (irqEdge),
    .stb       (stb),
    .irqOut    (irqOut)
  );

  pio_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .IRQ_BIT     (IRQ_BIT)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .rdData  (busRdData),
    .irqEdge (irqEdge)
  );
endmodule

// File: rtl/pio_checker.sv
module pio_checker
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PORT_W-1:0] busWrData,
  input logic              busRd,
  input logic              busWr,
  input logic [PORT_W-1:0] busRdData,
  input logic [PINS-1:0]   pinOut,
  input logic [PINS-1:0]   pinOe,
  input logic              irqOut
);
  logic ctrlWr;
  logic modeWr;
  logic clrWr;
  logic disRd;

  assign ctrlWr = busWr && !busAddr[3] && (busAddr[1:0] == 2'd3);
  assign modeWr = ctrlWr && busWrData[7];
  assign clrWr  = busWr && (busAddr == 4'hF);
  assign disRd  = busRd && (busAddr == 4'hB);

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busRd && busWr)); // R1

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busRd |=> $stable(busRdData)); // R1

  AST_DIR_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !modeWr |=> $stable(pinOe)); // R3

  AST_MODE_CLEARS_G0: assert property (@(posedge clk) disable iff (!rst_n)
    (modeWr && !busAddr[2]) |=> (pinOut[GROUP_W-1:0] == '0)); // R4

  AST_MODE_CLEARS_G1: assert property (@(posedge clk) disable iff (!rst_n)
    (modeWr && busAddr[2]) |=> (pinOut[PINS-1:GROUP_W] == '0)); // R4

  AST_BITCMD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWr && !busWrData[7]) |=> ($countones(pinOut ^ $past(pinOut)) <= 1)); // R5

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    disRd |=> !irqOut); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && !clrWr && !disRd) |=> irqOut); // R11

  AST_UNUSED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr[3] && (busAddr[1:0] != 2'd3)) |=>
      ($stable(pinOut) && $stable(pinOe))); // R12
endmodule

bind dual_pio_ctrl pio_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRd     (busRd),
  .busWr     (busWr),
  .busRdData (busRdData),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .irqOut    (irqOut)
);

// File: tb/sim_dual_pio_ctrl.sv
module sim_dual_pio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busRdData;
  logic [47:0] pinIn = '0;
  logic [47:0] pinOut;
  logic [47:0] pinOe;
  logic        irqOut;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  logic [7:0] mLat [6];
  logic [3:0] mDir [2];   // bit0 A, bit1 B, bit2 C low, bit3 C high; 1 = input

  dual_pio_ctrl u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [47:0] expOut();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = mLat[i];
    return v;
  endfunction

  function automatic logic [47:0] expOe();
    logic [47:0] v;
    for (int g = 0; g < 2; g++) begin
      v[g*24 +: 8]      = {8{~mDir[g][0]}};
      v[g*24 + 8 +: 8]  = {8{~mDir[g][1]}};
      v[g*24 + 16 +: 4] = {4{~mDir[g][2]}};
      v[g*24 + 20 +: 4] = {4{~mDir[g][3]}};
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkPins(input string tag);
    check(pinOut == expOut(), tag, pinOut, expOut());
    check(pinOe == expOe(), tag, pinOe, expOe());
  endtask

  task automatic modelWrite(input logic [3:0] a, input logic [7:0] d);
    int g, s;
    if (!a[3]) begin
      g = int'(a[2]);
      s = int'(a[1:0]);
      if (s == 3) begin
        if (d[7]) begin
          mDir[g] = {d[3], d[0], d[1], d[4]};
          for (int p = 0; p < 3; p++) mLat[g*3+p] = '0;
        end else begin
          mLat[g*3+2][d[3:1]] = d[0];
        end
      end else begin
        mLat[g*3+s] = d;
      end
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doRead(input logic [3:0] a);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [3:0] unusedA [6];
    logic [3:0] otherRd [8];
    logic [47:0] pat;
    logic [7:0] expByte;
    unusedA = '{4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'hE};
    otherRd = '{4'h3, 4'h7, 4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'hF};
    void'($urandom(32'd20240613));
    for (int i = 0; i < 6; i++) mLat[i] = '0;
    mDir[0] = '0; mDir[1] = '0;

    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);
    // R7 reset state
    checkPins("R7 reset pins");
    check(busRdData == 8'h00, "R7 reset rdData", 48'(busRdData), 48'h0);
    check(irqOut == 1'b0, "R7 reset irq", 48'(irqOut), 48'h0);

    // R1 directed reads of all six ports
    pinIn = 48'hA1B2C3D4E5F6 & ~(48'h1 << 19) & ~(48'h1 << 43);
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 3; p++) begin
        doRead(4'(g*4 + p));
        expByte = pinIn[(g*3+p)*8 +: 8];
        check(busRdData == expByte, "R1 port read", 48'(busRdData), 48'(expByte));
      end
    end
    doRead(4'h3);
    check(busRdData == 8'h00, "R1 control read zero", 48'(busRdData), 48'h0);

    // R2 port writes
    doWrite(4'h1, 8'h5A);
    doWrite(4'h6, 8'hC3);
    checkPins("R2 port write");

    // R3 mode words, including ignored bits 6,5,2
    doWrite(4'h3, 8'hF4 | 8'h10);
    checkPins("R3 mode A input");
    doWrite(4'h7, 8'h89);
    checkPins("R3 mode C nibbles input");
    // R6 write to input parts
    doWrite(4'h0, 8'h3C);
    doWrite(4'h6, 8'h96);
    checkPins("R6 input latch write");
    // R4 mode clears only its group
    doWrite(4'h4, 8'h11);
    doWrite(4'h3, 8'h82);
    checkPins("R4 mode clears group");
    // R5 bit commands
    doWrite(4'h3, 8'h0B);
    doWrite(4'h7, 8'h0F);
    doWrite(4'h7, 8'h0E);
    doWrite(4'h3, 8'h01);
    checkPins("R5 bit command");
    // R12 unused writes
    for (int k = 0; k < 6; k++) doWrite(unusedA[k], 8'hFF);
    checkPins("R12 unused writes");
    check(irqOut == 1'b0, "R12 no irq after unused writes", 48'(irqOut), 48'h0);

    // random traffic, interrupt pins held low
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: doWrite(4'($urandom_range(0, 1) * 4 + $urandom_range(0, 2)), 8'($urandom));
        1: doWrite($urandom_range(0, 1) ? 4'h7 : 4'h3, 8'($urandom) | 8'h80);
        2: doWrite($urandom_range(0, 1) ? 4'h7 : 4'h3, 8'($urandom) & 8'h7F);
        3: doWrite(unusedA[$urandom_range(0, 5)], 8'($urandom));
        4: begin
          int idx;
          pat = {$urandom, $urandom} & ~(48'h1 << 19) & ~(48'h1 << 43);
          pinIn = pat;
          idx = $urandom_range(0, 5);
          doRead(4'((idx / 3) * 4 + idx % 3));
          expByte = pat[idx*8 +: 8];
          check(busRdData == expByte, "R1 random read", 48'(busRdData), 48'(expByte));
        end
        default: begin
          doRead(otherRd[$urandom_range(0, 7)]);
          check(busRdData == 8'h00, "R1 random other read", 48'(busRdData), 48'h0);
        end
      endcase
      checkPins(op == 1 ? "R3 R4 random mode" :
                op == 2 ? "R5 random bitcmd" :
                op == 3 ? "R12 random unused" : "R2 R6 random");
    end

    // interrupts
    pinIn = '0;
    waitCyc(4);
    pinIn[19] = 1'b1;             // edge while disabled
    waitCyc(4);
    check(irqOut == 1'b0, "R8 edge while disabled", 48'(irqOut), 48'h0);
    pinIn[19] = 1'b0;
    waitCyc(4);
    doWrite(4'hB, 8'h5C);         // R9 enable, any value
    pinIn[20] = 1'b1;             // non-interrupt pin
    waitCyc(4);
    check(irqOut == 1'b0, "R8 other pin no irq", 48'(irqOut), 48'h0);
    pinIn[19] = 1'b1;
    waitCyc(2);
    check(irqOut == 1'b0, "R8 irq not before third edge", 48'(irqOut), 48'h0);
    waitCyc(1);
    check(irqOut == 1'b1, "R8 irq on pin 19 rise", 48'(irqOut), 48'h1);
    waitCyc(6);
    doWrite(4'h2, 8'h00);
    check(irqOut == 1'b1, "R11 irq holds", 48'(irqOut), 48'h1);
    doWrite(4'hF, 8'h00);
    check(irqOut == 1'b0, "R10 clear write", 48'(irqOut), 48'h0);
    pinIn[19] = 1'b0;             // falling edge
    waitCyc(4);
    check(irqOut == 1'b0, "R8 falling edge ignored", 48'(irqOut), 48'h0);
    pinIn[43] = 1'b1;
    waitCyc(4);
    check(irqOut == 1'b1, "R8 irq on pin 43 rise", 48'(irqOut), 48'h1);
    doRead(4'hB);
    check(irqOut == 1'b0, "R9 disabling read", 48'(irqOut), 48'h0);
    pinIn[43] = 1'b0;
    waitCyc(4);
    pinIn[43] = 1'b1;
    waitCyc(4);
    check(irqOut == 1'b0, "R9 stays disabled", 48'(irqOut), 48'h0);
    doWrite(4'hB, 8'h00);
    pinIn[43] = 1'b0;
    waitCyc(4);
    pinIn[43] = 1'b1;
    waitCyc(4);
    check(irqOut == 1'b1, "R9 re-enabled", 48'(irqOut), 48'h1);
    for (int k = 0; k < 6; k++) doWrite(unusedA[k], 8'h00);
    check(irqOut == 1'b1, "R12 unused writes keep irq", 48'(irqOut), 48'h1);
    checkPins("R12 pins after irq phase");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule